// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It copies data units from a source address to a destination address over a simple request/ready memory bus. Each unit is a read followed by a write. Software-style configuration inputs set the following:

- the start addresses and the unit size;
- whether each address steps or stays put;
- the transfer length and the interrupt threshold;
- the mode bits and the enable.

An activation comes in one of two ways. In immediate mode, raising the enable starts the channel and it runs by itself. In request mode, the channel waits for pulses on a hardware request line.

Normal mode stops once the programmed number of units has moved. Repeat mode wraps the counter and the addresses and keeps going. Three variants shape the traffic:

- **Fill:** the first source unit is read once and written to every destination slot.
- **Idle wait:** one bus cycle is left free after every store.
- **Bursts:** one hardware request moves 4 or 8 units, but only when the length divides evenly.

A sticky interrupt flag rises at a programmable count and is cleared by a pulse on `irq_clr`.

Top module: `dma_chan`

## Requirements
- R1: `cfg_size` selects the unit size: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. `mem_size` carries the same code. Each address, when its increment bit is set, advances by one unit after every completed unit; otherwise it stays fixed.
- R2: In normal mode (`cfg_repeat`=0), exactly `cfg_len` units move after the enable rises. Once that count is reached, no further bus access is issued, and any later `hw_req` pulse is ignored.
- R3: In repeat mode, when the counter reaches `cfg_len` it returns to 0, both addresses return to `cfg_src`/`cfg_dst`, and transfers continue.
- R4: `irq` is set on the write completion that brings the counter to `cfg_irq_at`. When `cfg_irq_at`=0, it is instead set on the completion that reaches `cfg_len` (in repeat mode, every pass). The flag stays high until an `irq_clr` pulse, and it never rises except on a completed write.
- R5: With `cfg_hw_start`=1, each `hw_req` pulse seen while the channel is idle moves one unit (or one burst, see R8). With `cfg_hw_start`=0, units run back to back until the length is reached.
- R6: With `cfg_fill`=1 and immediate start, the first unit of a pass reads the source once. Every destination unit of that pass then receives that same value, with no further reads.
- R7: With `cfg_idle_wait`=1, the cycle after every accepted write has `mem_req` low. With `cfg_idle_wait`=0, the next read is issued in the cycle right after the write is accepted.
- R8: In request mode, `cfg_burst`=1 selects bursts of 4 units and 2 selects bursts of 8; one `hw_req` then moves a whole burst. If `cfg_len` is not a multiple of the burst size, a request moves a single unit.
- R9: When `cfg_en` goes low, the unit in flight finishes and no new access starts. A later rising edge of `cfg_en` reloads both addresses and clears the counter.
- R10: A bus access holds `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready`. Each unit's write follows its read, and the counter and addresses update only when the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_size | input | 2 | Unit size code |
| cfg_src_inc | input | 1 | Step source address per unit |
| cfg_dst_inc | input | 1 | Step destination address per unit |
| cfg_len | input | CW | Units per pass (1 or more) |
| cfg_irq_at | input | CW | Interrupt count, 0 = end of pass |
| cfg_repeat | input | 1 | Repeat mode |
| cfg_hw_start | input | 1 | 1 = wait for hw_req, 0 = run immediately |
| cfg_fill | input | 1 | Fill variant (immediate start) |
| cfg_idle_wait | input | 1 | Idle cycle after each store |
| cfg_burst | input | 2 | 0 off, 1 = 4 units, 2 = 8 units |
| cfg_en | input | 1 | Channel enable |
| hw_req | input | 1 | Peripheral request |
| irq_clr | input | 1 | Clears the interrupt flag |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_size | output | 2 | Unit size code of the access |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Access accepted |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the channel with its default widths: 32-bit addresses and data, and a 16-bit counter. All traffic runs against a 256-byte byte-addressed memory model. Short lengths of 2 to 8 units bring the counter wrap, the threshold match, and burst divisibility into reach within a few dozen cycles. A ready line that can either follow the request or toggle every cycle exercises both single-cycle accesses and held accesses. The single-cycle case lets the bench measure the cycle spacing between a store and the next read.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic [CW-1:0] cfg_len,
  input  logic [CW-1:0] cfg_irq_at,
  input  logic          cfg_repeat,
  input  logic          cfg_hw_start,
  input  logic          cfg_fill,
  input  logic          cfg_idle_wait,
  input  logic [1:0]    cfg_burst,
  input  logic          cfg_en,
  input  logic          hw_req,
  input  logic          irq_clr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [1:0]    mem_size,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_GAP} st_t;

  st_t           st;
  logic [AW-1:0] cur_src, cur_dst;
  logic [CW-1:0] cnt;
  logic [DW-1:0] data_q;
  logic [2:0]    rem;
  logic          en_q, done, pend, irq_q;

  wire [AW-1:0] step    = (cfg_size == 2'd0) ? AW'(1) : (cfg_size == 2'd1) ? AW'(2) : AW'(4);
  wire [CW-1:0] cnt_inc = cnt + CW'(1);
  wire          wrap    = (cnt_inc == cfg_len);
  wire          fin     = wrap && !cfg_repeat;
  wire [CW-1:0] cnt_nx  = (wrap && cfg_repeat) ? '0 : cnt_inc;
  wire          hit     = (cfg_irq_at == '0) ? wrap : (cnt_inc == cfg_irq_at);
  wire [3:0]    bsz     = (cfg_burst == 2'd1) ? 4'd4 : (cfg_burst == 2'd2) ? 4'd8 : 4'd1;
  wire          b_ok    = (cfg_len & CW'(bsz - 4'd1)) == '0;
  wire [2:0]    rem_ini = b_ok ? 3'(bsz - 4'd1) : 3'd0;
  wire          fill_on = cfg_fill && !cfg_hw_start;
  wire          skip_i  = fill_on && (cnt != '0);
  wire          skip_w  = fill_on && (cnt_nx != '0);
  wire          more    = cfg_en && !fin && (rem != 3'd0 || !cfg_hw_start);
  wire          start   = cfg_en && en_q && !done && (!cfg_hw_start || hw_req);
  wire          rise    = cfg_en && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur_src <= '0;
      cur_dst <= '0;
      cnt     <= '0;
      data_q  <= '0;
      rem     <= '0;
      en_q    <= 1'b0;
      done    <= 1'b0;
      pend    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (irq_clr) irq_q <= 1'b0;
      if (st == S_WR && mem_ready && hit) irq_q <= 1'b1;
      if (rise) begin
        cur_src <= cfg_src;
        cur_dst <= cfg_dst;
        cnt     <= '0;
        done    <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          rem <= cfg_hw_start ? rem_ini : 3'd0;
          st  <= skip_i ? S_WR : S_RD;
        end
        S_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          st     <= S_WR;
        end
        S_WR: if (mem_ready) begin
          cnt  <= cnt_nx;
          done <= fin;
          if (wrap && cfg_repeat) begin
            cur_src <= cfg_src;
            cur_dst <= cfg_dst;
          end else begin
            cur_src <= cur_src + (cfg_src_inc ? step : '0);
            cur_dst <= cur_dst + (cfg_dst_inc ? step : '0);
          end
          if (rem != 3'd0) rem <= rem - 3'd1;
          if (cfg_idle_wait) begin
            pend <= more;
            st   <= S_GAP;
          end else begin
            st <= more ? (skip_w ? S_WR : S_RD) : S_IDLE;
          end
        end
        default: st <= (pend && cfg_en) ? (skip_i ? S_WR : S_RD) : S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? cur_dst : cur_src;
  assign mem_wdata = data_q;
  assign mem_size  = cfg_size;
  assign irq       = irq_q;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_idle_wait,
  input logic          irq_clr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          irq
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_idle_wait && mem_req && mem_we && mem_ready |=> !mem_req);

  assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !(mem_req && mem_we && mem_ready) |=> !irq);

  assert_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en && !mem_req |=> !mem_req);
endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [31:0] cfg_src, cfg_dst;
  logic [1:0]  cfg_size, cfg_burst;
  logic        cfg_src_inc, cfg_dst_inc, cfg_repeat, cfg_hw_start, cfg_fill, cfg_idle_wait, cfg_en;
  logic [15:0] cfg_len, cfg_irq_at;
  logic        hw_req, irq_clr;
  logic        mem_req, mem_we, mem_ready, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  dma_chan u_dut (.*);

  logic [7:0]  mem [0:255];
  logic        tog = 1'b0, slow = 1'b0, init_req = 1'b0;
  int          cyc = 0, n_log = 0, base = 0;
  int          checks = 0, fails = 0;
  logic [31:0] la [0:63];
  logic [31:0] ld [0:63];
  logic        lw [0:63];
  int          lc [0:63];

  wire [7:0] a = mem_addr[7:0];
  assign mem_rdata = {mem[8'(a + 8'd3)], mem[8'(a + 8'd2)], mem[8'(a + 8'd1)], mem[a]};
  assign mem_ready = mem_req && (!slow || tog);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tog <= ~tog;
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= (i < 128) ? 8'(i * 7 + 3) : 8'h00;
    end else if (mem_req && mem_ready) begin
      la[6'(n_log)] <= mem_addr;
      ld[6'(n_log)] <= mem_we ? mem_wdata : mem_rdata;
      lw[6'(n_log)] <= mem_we;
      lc[6'(n_log)] <= cyc;
      n_log <= n_log + 1;
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (k < (mem_size == 2'd0 ? 1 : mem_size == 2'd1 ? 2 : 4))
            mem[8'(a + 8'(k))] <= mem_wdata[8*k +: 8];
    end
  end

  function automatic logic [7:0] pat(int ad);
    return 8'(ad * 7 + 3);
  endfunction

  function automatic logic [31:0] pword(int ad);
    return {pat(ad + 3), pat(ad + 2), pat(ad + 1), pat(ad)};
  endfunction

  function automatic logic [31:0] rd32(int ad);
    return {mem[ad + 3], mem[ad + 2], mem[ad + 1], mem[ad]};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic setup(logic [31:0] s, logic [31:0] d, logic [1:0] sz, logic si, logic di,
                       logic [15:0] len, logic [15:0] ia, logic rp, logic hw, logic fl,
                       logic wt, logic [1:0] bu, logic sl);
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_src = s; cfg_dst = d; cfg_size = sz; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_len = len; cfg_irq_at = ia; cfg_repeat = rp; cfg_hw_start = hw; cfg_fill = fl;
    cfg_idle_wait = wt; cfg_burst = bu; slow = sl;
    init_req = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    init_req = 1'b0; irq_clr = 1'b0;
    base = n_log;
    cfg_en = 1'b1;
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int t = 0; t < 3000 && q < 10; t++) begin
      @(negedge clk);
      q = mem_req ? 0 : q + 1;
    end
  endtask

  task automatic pulse();
    @(negedge clk); hw_req = 1'b1;
    @(negedge clk); hw_req = 1'b0;
    wait_quiet();
  endtask

  function automatic int nl();
    return n_log - base;
  endfunction

  function automatic int ix(int k);
    return 32'(6'(base + k));
  endfunction

  task automatic t_reset();
    chk("R2 reset mem_req", 32'(mem_req), 0);
    chk("R4 reset irq", 32'(irq), 0);
  endtask

  task automatic t_copy();
    setup(32'h00, 32'h80, 2'd2, 1, 1, 16'd4, 16'd0, 0, 0, 0, 0, 2'd0, 1);
    wait_quiet();
    chk("R2 copy access count", 32'(nl()), 8);
    for (int k = 0; k < 4; k++) begin
      chk("R1 copy dst word", rd32(128 + 4 * k), pword(4 * k));
      chk("R10 read before write", 32'(lw[ix(2 * k)]), 0);
      chk("R10 write follows", 32'(lw[ix(2 * k + 1)]), 1);
    end
    chk("R4 irq at end", 32'(irq), 1);
  endtask

  task automatic t_sizes();
    setup(32'h00, 32'h90, 2'd0, 1, 0, 16'd3, 16'd0, 0, 0, 0, 0, 2'd0, 0);
    wait_quiet();
    chk("R1 fixed dst byte", 32'(mem[8'h90]), 32'(pat(2)));
    chk("R1 fixed dst addr", la[ix(5)], 32'h90);
    chk("R1 byte next untouched", 32'(mem[8'h91]), 0);
    setup(32'h10, 32'hA0, 2'd1, 1, 1, 16'd2, 16'd0, 0, 0, 0, 0, 2'd0, 0);
    wait_quiet();
    chk("R1 2B src step", la[ix(2)], 32'h12);
    chk("R1 2B dst step", la[ix(3)], 32'hA2);
    chk("R1 2B mem_size", 32'(mem_size), 1);
  endtask

  task automatic t_hw();
    setup(32'h00, 32'h80, 2'd2, 1, 1, 16'd2, 16'd0, 0, 1, 0, 0, 2'd0, 1);
    wait_quiet();
    chk("R5 no access before request", 32'(nl()), 0);
    pulse();
    chk("R5 one unit per request", 32'(nl()), 2);
    pulse();
    chk("R5 second request", 32'(nl()), 4);
    pulse();
    chk("R2 request after end ignored", 32'(nl()), 4);
  endtask

  task automatic t_repeat();
    setup(32'h00, 32'h80, 2'd1, 1, 1, 16'd2, 16'd0, 1, 1, 0, 0, 2'd0, 0);
    pulse();
    chk("R4 no irq mid pass", 32'(irq), 0);
    pulse();
    chk("R4 irq at pass end", 32'(irq), 1);
    pulse();
    chk("R3 dst reloaded", la[ix(5)], 32'h80);
    chk("R3 src reloaded", la[ix(4)], 32'h00);
  endtask

  task automatic t_thresh();
    setup(32'h00, 32'h80, 2'd2, 1, 1, 16'd4, 16'd2, 0, 1, 0, 0, 2'd0, 0);
    pulse();
    chk("R4 below threshold", 32'(irq), 0);
    pulse();
    chk("R4 at threshold", 32'(irq), 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R4 cleared", 32'(irq), 0);
    pulse();
    pulse();
    chk("R4 not again past threshold", 32'(irq), 0);
  endtask

  task automatic t_fill();
    setup(32'h08, 32'h80, 2'd2, 1, 1, 16'd4, 16'd0, 0, 0, 1, 0, 2'd0, 1);
    wait_quiet();
    chk("R6 accesses one read plus writes", 32'(nl()), 5);
    chk("R6 first is read", 32'(lw[ix(0)]), 0);
    for (int k = 0; k < 4; k++) chk("R6 replicated word", rd32(128 + 4 * k), pword(8));
  endtask

  task automatic t_gap();
    setup(32'h00, 32'h80, 2'd2, 1, 1, 16'd3, 16'd0, 0, 0, 0, 0, 2'd0, 0);
    wait_quiet();
    chk("R7 back to back", 32'(lc[ix(2)] - lc[ix(1)]), 1);
    setup(32'h00, 32'h80, 2'd2, 1, 1, 16'd3, 16'd0, 0, 0, 0, 1, 2'd0, 0);
    wait_quiet();
    chk("R7 idle cycle", 32'(lc[ix(2)] - lc[ix(1)]), 2);
    chk("R7 idle cycle 2", 32'(lc[ix(4)] - lc[ix(3)]), 2);
    chk("R7 all units moved", 32'(nl()), 6);
  endtask

  task automatic t_burst();
    setup(32'h00, 32'h80, 2'd2, 1, 1, 16'd8, 16'd0, 0, 1, 0, 0, 2'd1, 0);
    pulse();
    chk("R8 burst of 4", 32'(nl()), 8);
    pulse();
    chk("R8 second burst", 32'(nl()), 16);
    setup(32'h00, 32'h80, 2'd2, 1, 1, 16'd6, 16'd0, 0, 1, 0, 0, 2'd1, 0);
    pulse();
    chk("R8 length not multiple single", 32'(nl()), 2);
  endtask

  task automatic t_abort();
    setup(32'h00, 32'h80, 2'd2, 1, 1, 16'd8, 16'd0, 0, 0, 0, 0, 2'd0, 1);
    for (int t = 0; t < 500 && nl() < 4; t++) @(negedge clk);
    cfg_en = 1'b0;
    wait_quiet();
    chk("R9 stops after unit in flight", 32'(nl()), 6);
    base = n_log;
    cfg_en = 1'b1;
    wait_quiet();
    chk("R9 restart full length", 32'(nl()), 16);
    chk("R9 restart dst reloaded", la[ix(1)], 32'h80);
  endtask

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; hw_req = 1'b0; irq_clr = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_size = '0; cfg_src_inc = 0; cfg_dst_inc = 0;
    cfg_len = 16'd1; cfg_irq_at = '0; cfg_repeat = 0; cfg_hw_start = 0; cfg_fill = 0;
    cfg_idle_wait = 0; cfg_burst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy();
    t_sizes();
    t_hw();
    t_repeat();
    t_thresh();
    t_fill();
    t_gap();
    t_burst();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule